// File: doc/BRIEF.md
# Bidirectional X/Y Byte-Pair Address Generator

This block takes a 16-bit half-word access from the host and splits it into two byte cycles on a bit map of 64K locations. Each location is 8 bits wide in each of 4 planes. The host byte address is shifted right by one bit to give the location address. The high data byte is carried at that location.

The low data byte goes to a neighbouring location rather than to the next address. The neighbour is one step away along the horizontal or the vertical axis, in the increasing or the decreasing direction. Two mode bits choose the axis and the direction. A horizontal step is one location and a vertical step is one line pitch. All address arithmetic wraps around the location space. Because of this, a word access can start on any byte and move in any of four directions, and every location can be reached through two host addresses.

The block issues the high-byte cycle first and the low-byte cycle second. It then pulses a done strobe, and on a read it presents both bytes as a 16-bit word.

Top module: `xy_pair_addr_gen`

## Requirements
- R1: While reset is held, and in the cycle after it, mem_valid, busy and done are all 0.
- R2: The location address is host_addr[16:1]. host_addr[0] has no effect on any memory cycle or on the read data.
- R3: In the cycle after an accepted request, mem_valid=1, mem_lane_hi=1 and mem_addr is the location. mem_wbyte is wdata[15:8].
- R4: In the next cycle, mem_valid=1, mem_lane_hi=0 and mem_addr is the neighbour. mem_wbyte is wdata[7:0].
- R5: With step_y=0, the neighbour is location+1 when step_dec=0 and location-1 when step_dec=1.
- R6: With step_y=1, the neighbour is location+LINE_PITCH (default 128) when step_dec=0 and location-LINE_PITCH when step_dec=1.
- R7: Neighbour arithmetic wraps modulo 2^16, so 0xFFFF+1 gives 0x0000 and 0x0000-128 gives 0xFF80.
- R8: done is 1 for exactly one cycle, in the cycle after the low-byte cycle. At that point rdata is {mem_rdata at location, mem_rdata at neighbour}, with the high byte in rdata[15:8].
- R9: A request made while busy=1 is ignored. The current access keeps its address, and no extra cycle follows it.
- R10: host_addr, wdata, is_write, step_dec and step_y are sampled when a request is accepted. Changing them during the access has no effect.
- R11: mem_we equals the accepted is_write value on both byte cycles, and mem_valid is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a word access (accepted when idle) |
| host_addr | input | 17 | Host byte address inside the window |
| is_write | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Host write word |
| step_dec | input | 1 | 1 = neighbour one step down, 0 = one step up |
| step_y | input | 1 | 1 = vertical step, 0 = horizontal step |
| mem_valid | output | 1 | A byte cycle is active |
| mem_addr | output | 16 | Location address of the byte cycle |
| mem_we | output | 1 | Byte cycle writes |
| mem_lane_hi | output | 1 | 1 = high host byte lane, 0 = low lane |
| mem_wbyte | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read from the addressed location (same cycle) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 16 | Assembled read word |

## Verification
Word accesses are run in all four step directions, with read data that depends on the address. A mix-up of axis or sign therefore shows up in both the neighbour address and the low byte returned. Accesses at 0xFFFF and 0x0000 separate correct modulo wrap from a carry into a wider result. An odd host address is checked against its even twin to show that bit 0 is ignored. A request made in mid-access, together with changes to the mode bits and the address, shows that the latched values are held. A write access checks byte-lane steering against the read case.

// File: rtl/xy_pair_pkg.sv
package xy_pair_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HI   = 2'd1,
        PH_LO   = 2'd2
    } phase_t;

    typedef struct packed {
        logic dec;
        logic y_axis;
    } step_cfg_t;

    // Signed step applied to the location address to reach the partner byte.
    function automatic int step_delta(step_cfg_t cfg, int pitch);
        int mag;
        mag = cfg.y_axis ? pitch : 1;
        return cfg.dec ? -mag : mag;
    endfunction

endpackage

// File: rtl/xy_step_unit.sv
module xy_step_unit
    import xy_pair_pkg::*;
#(
    parameter int LOC_W      = 16,
    parameter int LINE_PITCH = 128
) (
    input  logic [LOC_W-1:0] loc,
    input  step_cfg_t        cfg,
    output logic [LOC_W-1:0] nbr
);
    logic [LOC_W-1:0] delta;

    always_comb begin
        delta = LOC_W'(step_delta(cfg, LINE_PITCH));
        nbr   = loc + delta;   // truncation gives modulo 2^LOC_W wrap
    end

    always_comb begin
        if (cfg.y_axis == 1'b0 && cfg.dec == 1'b0 && loc == '1)
            p_wrap_top_r7: assert (nbr == '0);
    end
endmodule

// File: rtl/xy_sequencer.sv
module xy_sequencer
    import xy_pair_pkg::*;
#(
    parameter int LOC_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [LOC_W-1:0]  loc_in,
    input  step_cfg_t         cfg_in,
    input  logic              we_in,
    input  logic [DATA_W-1:0] wdata_in,
    output phase_t            phase,
    output logic [LOC_W-1:0]  loc_q,
    output step_cfg_t         cfg_q,
    output logic              we_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            done    <= 1'b0;
            loc_q   <= '0;
            cfg_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            done <= (phase == PH_LO);
            unique case (phase)
                PH_IDLE: if (req) begin
                    loc_q   <= loc_in;
                    cfg_q   <= cfg_in;
                    we_q    <= we_in;
                    wdata_q <= wdata_in;
                    phase   <= PH_HI;
                end
                PH_HI:   phase <= PH_LO;
                PH_LO:   phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    p_hi_then_lo_r4: assert property (@(posedge clk) disable iff (rst)
        phase == PH_HI |=> phase == PH_LO);

    p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
        phase != PH_IDLE |=> $stable(loc_q) && $stable(cfg_q) && $stable(wdata_q));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/xy_byte_lanes.sv
module xy_byte_lanes
    import xy_pair_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase,
    input  logic [2*BYTE_W-1:0] wdata_q,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] wbyte,
    output logic [2*BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (phase == PH_HI) hi_q <= mem_rdata;
            if (phase == PH_LO) lo_q <= mem_rdata;
        end
    end

    always_comb begin
        wbyte = (phase == PH_HI) ? wdata_q[2*BYTE_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
        rdata = {hi_q, lo_q};
    end

    p_hi_capture_r8: assert property (@(posedge clk) disable iff (rst)
        phase == PH_HI |=> hi_q == $past(mem_rdata));
endmodule

// File: rtl/xy_pair_addr_gen.sv
module xy_pair_addr_gen
    import xy_pair_pkg::*;
#(
    parameter int LOC_W      = 16,
    parameter int BYTE_W     = 8,
    parameter int LINE_PITCH = 128,
    localparam int HOST_W    = LOC_W + 1,
    localparam int DATA_W    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [HOST_W-1:0] host_addr,
    input  logic              is_write,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step_dec,
    input  logic              step_y,
    output logic              mem_valid,
    output logic [LOC_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic              mem_lane_hi,
    output logic [BYTE_W-1:0] mem_wbyte,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    phase_t            phase;
    logic [LOC_W-1:0]  loc_q, nbr;
    step_cfg_t         cfg_in, cfg_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;

    assign cfg_in = '{dec: step_dec, y_axis: step_y};

    xy_sequencer #(.LOC_W(LOC_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst), .req(req),
        .loc_in(host_addr[HOST_W-1:1]), .cfg_in(cfg_in),
        .we_in(is_write), .wdata_in(wdata),
        .phase(phase), .loc_q(loc_q), .cfg_q(cfg_q),
        .we_q(we_q), .wdata_q(wdata_q), .done(done)
    );

    xy_step_unit #(.LOC_W(LOC_W), .LINE_PITCH(LINE_PITCH)) u_step (
        .loc(loc_q), .cfg(cfg_q), .nbr(nbr)
    );

    xy_byte_lanes #(.BYTE_W(BYTE_W)) u_lanes (
        .clk(clk), .rst(rst), .phase(phase), .wdata_q(wdata_q),
        .mem_rdata(mem_rdata), .wbyte(mem_wbyte), .rdata(rdata)
    );

    always_comb begin
        mem_valid   = (phase != PH_IDLE);
        mem_lane_hi = (phase == PH_HI);
        mem_addr    = (phase == PH_HI) ? loc_q : nbr;
        mem_we      = mem_valid && we_q;
        busy        = mem_valid;
    end

    p_lane_order_r3: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_lane_hi |=> mem_valid && !mem_lane_hi);

    p_x_step_r5: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_lane_hi && !cfg_q.y_axis |->
        LOC_W'(mem_addr - $past(mem_addr)) == (cfg_q.dec ? {LOC_W{1'b1}} : LOC_W'(1)));

    p_done_after_lo_r8: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_lane_hi |=> done && !mem_valid);

    p_we_const_r11: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_lane_hi |=> mem_we == $past(mem_we));
endmodule

// File: tb/xy_pair_addr_gen_test.sv
module xy_pair_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [16:0] host_addr;
    logic        is_write;
    logic [15:0] wdata;
    logic        step_dec, step_y;
    logic        mem_valid, mem_we, mem_lane_hi, busy, done;
    logic [15:0] mem_addr, rdata;
    logic [7:0]  mem_wbyte, mem_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // Address-dependent read data
    function automatic logic [7:0] pattern(logic [15:0] a);
        return a[7:0] ^ {a[15:9], 1'b0} ^ 8'h5A;
    endfunction
    assign mem_rdata = pattern(mem_addr);

    xy_pair_addr_gen uut (
        .clk(clk), .rst(rst), .req(req), .host_addr(host_addr),
        .is_write(is_write), .wdata(wdata), .step_dec(step_dec), .step_y(step_y),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_lane_hi(mem_lane_hi), .mem_wbyte(mem_wbyte), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .rdata(rdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] nbr_of(logic [15:0] loc, bit dec, bit y);
        logic [15:0] d;
        d = y ? 16'd128 : 16'd1;
        return dec ? loc - d : loc + d;
    endfunction

    // One word access; disturb=1 makes a new request and changes the mode bits mid-access.
    task automatic access(input logic [16:0] a, input bit we, input logic [15:0] wd,
                          input bit dec, input bit y, input string tag, input bit disturb);
        logic [15:0] loc, nb;
        loc = a[16:1];
        nb  = nbr_of(loc, dec, y);
        @(negedge clk);
        req = 1; host_addr = a; is_write = we; wdata = wd; step_dec = dec; step_y = y;
        @(negedge clk);
        req = disturb;
        if (disturb) begin
            host_addr = ~a; step_dec = ~dec; step_y = ~y; wdata = ~wd; is_write = ~we;
        end
        check(mem_valid && mem_lane_hi, "R3", "hi cycle valid/lane", {mem_valid, mem_lane_hi}, 2'b11);
        check(mem_addr == loc, "R2", "hi address", mem_addr, loc);
        check(mem_we == we, "R11", "hi we", mem_we, we);
        if (we) check(mem_wbyte == wd[15:8], "R3", "hi wbyte", mem_wbyte, wd[15:8]);
        @(negedge clk);
        check(mem_valid && !mem_lane_hi, "R4", "lo cycle valid/lane", {mem_valid, mem_lane_hi}, 2'b10);
        check(mem_addr == nb, tag, "neighbour address", mem_addr, nb);
        check(mem_we == we, "R11", "lo we", mem_we, we);
        if (we) check(mem_wbyte == wd[7:0], "R4", "lo wbyte", mem_wbyte, wd[7:0]);
        @(negedge clk);
        req = 0;
        check(done && !mem_valid, "R8", "done after lo", {done, mem_valid}, 2'b10);
        if (!we) check(rdata == {pattern(loc), pattern(nb)}, "R8", "read word",
                       rdata, {pattern(loc), pattern(nb)});
        @(negedge clk);
        check(!done, "R8", "done single pulse", done, 0);
        if (disturb) check(!mem_valid, "R9", "no extra cycle", mem_valid, 0);
    endtask

    task automatic test_reset();
        rst = 1; req = 0; host_addr = 0; is_write = 0; wdata = 0; step_dec = 0; step_y = 0;
        repeat (3) @(negedge clk);
        check(!mem_valid && !busy && !done, "R1", "in reset", {mem_valid, busy, done}, 0);
        rst = 0;
        @(negedge clk);
        check(!mem_valid && !busy && !done, "R1", "after reset", {mem_valid, busy, done}, 0);
    endtask

    task automatic test_odd_bit();
        // host_addr bit 0 set: same location as its even twin
        access(17'h0_2469, 0, 16'h0, 0, 0, "R2", 0);
    endtask

    initial begin
        test_reset();
        access(17'h0_1234, 0, 16'h0, 0, 0, "R5", 0);
        access(17'h0_1234, 0, 16'h0, 1, 0, "R5", 0);
        access(17'h0_8000, 0, 16'h0, 0, 1, "R6", 0);
        access(17'h0_8000, 0, 16'h0, 1, 1, "R6", 0);
        access(17'h1_FFFE, 0, 16'h0, 0, 0, "R7", 0);
        access(17'h0_0000, 0, 16'h0, 1, 1, "R7", 0);
        test_odd_bit();
        access(17'h0_4442, 1, 16'hA5C3, 1, 0, "R11", 0);
        access(17'h0_0A00, 0, 16'h0, 0, 1, "R10", 1);
        access(17'h0_0B02, 1, 16'h3C96, 1, 1, "R9", 1);
        finish_run();
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule